// File: doc/BRIEF.md
# Packet Radio Auto-Mode Sequencer

This block moves a packet radio through a short sequence of operating modes on its own, so the host processor does not have to step in. The host programs a resting (final) mode, a temporary (intermediate) mode, and one code each for the event that starts the sequence and the event that ends it. While the sequence is idle, the block reports the final mode. When the selected start event is seen, the block switches the radio into the intermediate mode and raises a level flag. When the selected end event is seen, it drops the flag and returns the radio to the final mode.

Events come from seven status lines of the packet engine. A line may carry a one-cycle pulse or a held level. Each line is reduced to its edges inside the block, so a level that stays high triggers only once. Typical uses are a receive-then-sleep cycle that waits for the host to drain the FIFO, and a transmit that is followed by listening for an acknowledge. Analog settling and synthesizer locking are handled outside this block.

Top module: `auto_mode_seq`

## Requirements
- R1: After a synchronous active-high reset, `mode_out` is 00 (sleep), `auto_active` is 0, and the stored final mode is 00.
- R2: Modes are coded 00 sleep, 01 standby, 10 receive, 11 transmit. While `auto_active` is 0, `mode_out` equals the stored final mode. A pulse on `final_mode_wr` stores `final_mode`, and the new value shows on `mode_out` one cycle later.
- R3: With both condition codes nonzero, a selected start event raises `auto_active` one cycle later, and `mode_out` then shows `inter_mode`.
- R4: Start codes on `enter_sel`: 001 rise of packet_sent, 010 rise of fifo_level, 011 rise of crc_ok, 100 rise of payload_ready, 101 rise of sync_addr_match, 110 rise of fifo_not_empty, 111 fall of fifo_not_empty.
- R5: End codes on `exit_sel`: 001 fall of fifo_not_empty, 010 rise of fifo_level or timeout, 011 rise of crc_ok or timeout, 100 rise of payload_ready or timeout, 101 rise of sync_addr_match or timeout, 110 rise of packet_sent, 111 rise of timeout. A selected end event while active clears `auto_active` one cycle later, and `mode_out` returns to the final mode.
- R6: Only edges count. A status line that stays high neither starts a new sequence nor ends the current one.
- R7: Code 000 in either `enter_sel` or `exit_sel` turns the function off. No sequence starts, and a running sequence ends on the next cycle.
- R8: A `final_mode_wr` pulse while active ends the sequence on the next cycle. The newly written mode then shows on `mode_out`. A write in the same cycle as a start event blocks the start.
- R9: An end event in the same cycle as the start event is ignored. End events are only looked for from the cycle after the start.
- R10: `auto_active` stays high for as long as the intermediate mode is shown. While it is high, `mode_out` follows `inter_mode` with one cycle of delay.
- R11: The two presets work as intended. The receive preset is final receive, intermediate sleep, start on crc_ok rise (011), end on fifo_not_empty fall (001). The acknowledge preset is final transmit, intermediate receive, start on packet_sent rise (001), end on crc_ok rise (011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| final_mode | input | 2 | Final mode value to store |
| final_mode_wr | input | 1 | One-cycle strobe that stores `final_mode` |
| inter_mode | input | 2 | Intermediate mode shown while active |
| enter_sel | input | 3 | Start event code |
| exit_sel | input | 3 | End event code |
| fifo_not_empty | input | 1 | FIFO holds data |
| fifo_level | input | 1 | FIFO level threshold reached |
| crc_ok | input | 1 | CRC check passed |
| payload_ready | input | 1 | Payload fully received |
| sync_addr_match | input | 1 | Sync word or address matched |
| packet_sent | input | 1 | Packet fully transmitted |
| timeout | input | 1 | Receive timeout |
| mode_out | output | 2 | Current mode seen by the radio (registered) |
| auto_active | output | 1 | High while the intermediate mode is in effect |

## Verification
Directed runs apply single-cycle pulses and held levels on the same status line. This separates edge triggering from level triggering. Start and end events are also placed in the same cycle, which shows whether end detection is held off on the start cycle. Host writes are placed both during a sequence and on a start cycle, which tells an abort apart from a normal return. A long run then drives pseudo-random status patterns under changing condition codes, including code 000. A behavioural model is compared against the outputs on every clock, which checks every start and end code against its own mix of status lines.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
  localparam int MODE_W = 2;
  localparam int SEL_W  = 3;
  localparam int NSTAT  = 7;

  // status vector bit positions
  localparam int S_FNE  = 0;
  localparam int S_LVL  = 1;
  localparam int S_CRC  = 2;
  localparam int S_PAY  = 3;
  localparam int S_SYNC = 4;
  localparam int S_SENT = 5;
  localparam int S_TMO  = 6;

  typedef enum logic [MODE_W-1:0] {
    MD_SLEEP = 2'b00,
    MD_STBY  = 2'b01,
    MD_RX    = 2'b10,
    MD_TX    = 2'b11
  } mode_e;
endpackage

// File: rtl/amseq_edge.sv
module amseq_edge #(
  parameter int N        = 7,
  parameter int FALL_IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic         fall_one
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end

  assign fall_one = ~lvl[FALL_IDX] & lvl_q[FALL_IDX];
endmodule

// File: rtl/amseq_cond.sv
module amseq_cond
  import amseq_pkg::*;
#(
  parameter int N = NSTAT,
  parameter int W = SEL_W
) (
  input  logic [N-1:0] rise,
  input  logic         fne_fall,
  input  logic [W-1:0] enter_sel,
  input  logic [W-1:0] exit_sel,
  output logic         enter_hit,
  output logic         exit_hit
);
  always_comb begin
    case (enter_sel)
      3'd1:    enter_hit = rise[S_SENT];
      3'd2:    enter_hit = rise[S_LVL];
      3'd3:    enter_hit = rise[S_CRC];
      3'd4:    enter_hit = rise[S_PAY];
      3'd5:    enter_hit = rise[S_SYNC];
      3'd6:    enter_hit = rise[S_FNE];
      3'd7:    enter_hit = fne_fall;
      default: enter_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (exit_sel)
      3'd1:    exit_hit = fne_fall;
      3'd2:    exit_hit = rise[S_LVL]  | rise[S_TMO];
      3'd3:    exit_hit = rise[S_CRC]  | rise[S_TMO];
      3'd4:    exit_hit = rise[S_PAY]  | rise[S_TMO];
      3'd5:    exit_hit = rise[S_SYNC] | rise[S_TMO];
      3'd6:    exit_hit = rise[S_SENT];
      3'd7:    exit_hit = rise[S_TMO];
      default: exit_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/amseq_ctrl.sv
module amseq_ctrl
  import amseq_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enabled,
  input  logic          enter_hit,
  input  logic          exit_hit,
  input  logic          final_wr,
  input  logic [MW-1:0] final_in,
  input  logic [MW-1:0] inter_in,
  output logic [MW-1:0] mode_q,
  output logic          active_q
);
  logic [MW-1:0] final_q, final_nx;
  logic          active_nx;

  always_comb begin
    final_nx = final_wr ? final_in : final_q;
    if (!active_q) active_nx = enabled && enter_hit && !final_wr;
    else           active_nx = enabled && !final_wr && !exit_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      final_q  <= MW'(MD_SLEEP);
      active_q <= 1'b0;
      mode_q   <= MW'(MD_SLEEP);
    end else begin
      final_q  <= final_nx;
      active_q <= active_nx;
      mode_q   <= active_nx ? inter_in : final_nx;
    end
  end
endmodule

// File: rtl/auto_mode_seq.sv
module auto_mode_seq
  import amseq_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] final_mode,
  input  logic          final_mode_wr,
  input  logic [MW-1:0] inter_mode,
  input  logic [SW-1:0] enter_sel,
  input  logic [SW-1:0] exit_sel,
  input  logic          fifo_not_empty,
  input  logic          fifo_level,
  input  logic          crc_ok,
  input  logic          payload_ready,
  input  logic          sync_addr_match,
  input  logic          packet_sent,
  input  logic          timeout,
  output logic [MW-1:0] mode_out,
  output logic          auto_active
);
  localparam int NS = NSTAT;

  logic [NS-1:0] stat, rise;
  logic          fne_fall, enter_hit, exit_hit, enabled;

  always_comb begin
    stat         = '0;
    stat[S_FNE]  = fifo_not_empty;
    stat[S_LVL]  = fifo_level;
    stat[S_CRC]  = crc_ok;
    stat[S_PAY]  = payload_ready;
    stat[S_SYNC] = sync_addr_match;
    stat[S_SENT] = packet_sent;
    stat[S_TMO]  = timeout;
  end

  assign enabled = (enter_sel != '0) && (exit_sel != '0);

  amseq_edge #(.N(NS), .FALL_IDX(S_FNE)) u_edge (
    .clk(clk), .rst(rst), .lvl(stat), .rise(rise), .fall_one(fne_fall)
  );

  amseq_cond #(.N(NS), .W(SW)) u_cond (
    .rise(rise), .fne_fall(fne_fall), .enter_sel(enter_sel),
    .exit_sel(exit_sel), .enter_hit(enter_hit), .exit_hit(exit_hit)
  );

  amseq_ctrl #(.MW(MW)) u_ctrl (
    .clk(clk), .rst(rst), .enabled(enabled), .enter_hit(enter_hit),
    .exit_hit(exit_hit), .final_wr(final_mode_wr), .final_in(final_mode),
    .inter_in(inter_mode), .mode_q(mode_out), .active_q(auto_active)
  );
endmodule

// File: rtl/amseq_chk.sv
module amseq_chk #(
  parameter int MW = 2,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [MW-1:0] final_mode,
  input logic          final_mode_wr,
  input logic [MW-1:0] inter_mode,
  input logic [SW-1:0] enter_sel,
  input logic [SW-1:0] exit_sel,
  input logic [MW-1:0] mode_out,
  input logic          auto_active
);
  logic          rst_d = 1'b0;
  logic [MW-1:0] fin_track;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)                fin_track <= '0;
    else if (final_mode_wr) fin_track <= final_mode;
  end

  always @(posedge clk)
    if (rst_d) AST_RESET_STATE: assert (!auto_active && mode_out == '0); // R1

  AST_IDLE_SHOWS_FINAL: assert property (@(posedge clk) disable iff (rst)
    !auto_active |-> mode_out == fin_track); // R2

  AST_ACTIVE_SHOWS_INTER: assert property (@(posedge clk) disable iff (rst)
    auto_active |-> mode_out == $past(inter_mode)); // R10

  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (rst)
    final_mode_wr |=> !auto_active); // R8

  AST_OFF_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
    (enter_sel == '0 || exit_sel == '0) |=> !auto_active); // R7
endmodule

bind auto_mode_seq amseq_chk #(.MW(MW), .SW(SW)) i_chk (
  .clk(clk), .rst(rst), .final_mode(final_mode), .final_mode_wr(final_mode_wr),
  .inter_mode(inter_mode), .enter_sel(enter_sel), .exit_sel(exit_sel),
  .mode_out(mode_out), .auto_active(auto_active)
);

// File: tb/test_auto_mode_seq.sv
`timescale 1ns/1ps
module test_auto_mode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] final_mode = 2'b00, inter_mode = 2'b00;
  logic       final_mode_wr = 1'b0;
  logic [2:0] enter_sel = 3'd0, exit_sel = 3'd0;
  logic [6:0] st = '0; // 0 fne,1 lvl,2 crc,3 pay,4 sync,5 sent,6 tmo
  logic [1:0] mode_out;
  logic       auto_active;

  int checks = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit [6:0] prv = '0;
  bit [1:0] m_final = 0, m_mode = 0;
  bit       m_act = 0;

  always #2.5 clk = ~clk;

  auto_mode_seq i_auto_mode_seq (
    .clk(clk), .rst(rst), .final_mode(final_mode), .final_mode_wr(final_mode_wr),
    .inter_mode(inter_mode), .enter_sel(enter_sel), .exit_sel(exit_sel),
    .fifo_not_empty(st[0]), .fifo_level(st[1]), .crc_ok(st[2]),
    .payload_ready(st[3]), .sync_addr_match(st[4]), .packet_sent(st[5]),
    .timeout(st[6]), .mode_out(mode_out), .auto_active(auto_active)
  );

  function automatic bit start_seen(input bit [2:0] c, input bit [6:0] up, input bit dn);
    case (c)
      1: return up[5];
      2: return up[1];
      3: return up[2];
      4: return up[3];
      5: return up[4];
      6: return up[0];
      7: return dn;
      default: return 0;
    endcase
  endfunction

  function automatic bit end_seen(input bit [2:0] c, input bit [6:0] up, input bit dn);
    case (c)
      1: return dn;
      2: return up[1] || up[6];
      3: return up[2] || up[6];
      4: return up[3] || up[6];
      5: return up[4] || up[6];
      6: return up[5];
      7: return up[6];
      default: return 0;
    endcase
  endfunction

  // drive inputs (called after a falling edge), predict, then compare
  task automatic step(input bit [6:0] s, input bit wr, input bit [1:0] fm, input string tag);
    bit [6:0] up;
    bit dn, on;
    st = s; final_mode_wr = wr; final_mode = fm;
    up = s & ~prv;
    dn = !s[0] && prv[0];
    on = (enter_sel != 0) && (exit_sel != 0);
    if (wr) m_final = fm;
    if (!m_act) m_act = on && start_seen(enter_sel, up, dn) && !wr;
    else        m_act = on && !wr && !end_seen(exit_sel, up, dn);
    m_mode = m_act ? inter_mode : m_final;
    prv = s;
    @(posedge clk); #1;
    checks++;
    if (mode_out !== m_mode || auto_active !== m_act) begin
      bad++;
      $display("FAIL %s: mode_out=%0d active=%0d expected mode=%0d active=%0d",
               tag, mode_out, auto_active, m_mode, m_act);
    end
    @(negedge clk);
    final_mode_wr = 0;
  endtask

  task automatic expect_state(input bit act, input bit [1:0] md, input string tag);
    checks++;
    if (auto_active !== act || mode_out !== md) begin
      bad++;
      $display("FAIL %s: mode_out=%0d active=%0d expected mode=%0d active=%0d",
               tag, mode_out, auto_active, md, act);
    end
  endtask

  task automatic cfg(input bit [1:0] im, input bit [2:0] en, input bit [2:0] ex);
    inter_mode = im; enter_sel = en; exit_sel = ex;
  endtask

  initial begin
    bit [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    expect_state(0, 2'b00, "R1 reset");

    step(0, 1, 2'b10, "R2 write final");
    expect_state(0, 2'b10, "R2 final rx shown");

    // basic start / end, edges only
    cfg(2'b01, 3'd3, 3'd4);
    step(7'b0000100, 0, 0, "R3 start on crc");
    expect_state(1, 2'b01, "R3 intermediate shown");
    step(7'b0000100, 0, 0, "R6 held crc");
    step(7'b0000100, 0, 0, "R10 stays active");
    step(7'b0001100, 0, 0, "R5 end on payload");
    expect_state(0, 2'b10, "R5 back to final");
    step(7'b0001100, 0, 0, "R6 held levels no restart");
    step(0, 0, 0, "R6 drop");
    step(7'b0000100, 0, 0, "R3 start again");
    step(7'b1000000, 0, 0, "R5 end on timeout");
    expect_state(0, 2'b10, "R5 timeout end");

    // start and end in the same cycle
    step(7'b0001100, 0, 0, "R9 start with end event");
    expect_state(1, 2'b01, "R9 same cycle end ignored");
    step(7'b0001100, 0, 0, "R9 held end level");
    step(7'b0000100, 0, 0, "R9 drop payload");
    step(7'b0001100, 0, 0, "R9 later end accepted");
    expect_state(0, 2'b10, "R9 end after start");

    // host write aborts
    step(0, 0, 0, "R8 idle");
    step(7'b0000100, 0, 0, "R8 start");
    step(7'b0000100, 1, 2'b11, "R8 write while active");
    expect_state(0, 2'b11, "R8 abort to new final");
    step(0, 0, 0, "R8 idle2");
    step(7'b0000100, 1, 2'b10, "R8 write blocks start");
    expect_state(0, 2'b10, "R8 start blocked");

    // codes of none
    step(0, 0, 0, "R7 idle");
    cfg(2'b01, 3'd0, 3'd4);
    step(7'b0000100, 0, 0, "R7 start code none");
    expect_state(0, 2'b10, "R7 no start");
    cfg(2'b01, 3'd3, 3'd0);
    step(0, 0, 0, "R7 idle3");
    step(7'b0000100, 0, 0, "R7 end code none");
    expect_state(0, 2'b10, "R7 no start exit none");
    cfg(2'b01, 3'd3, 3'd4);
    step(0, 0, 0, "R7 re-enable");
    step(7'b0000100, 0, 0, "R7 start");
    cfg(2'b01, 3'd3, 3'd0);
    step(7'b0000100, 0, 0, "R7 disable while active");
    expect_state(0, 2'b10, "R7 ended by none");

    // receive preset
    cfg(2'b00, 3'd3, 3'd1);
    step(0, 1, 2'b10, "R11 rx preset final");
    step(7'b0000001, 0, 2'b10, "R11 fifo fills");
    step(7'b0000101, 0, 2'b10, "R11 crc ok");
    expect_state(1, 2'b00, "R11 sleep while draining");
    step(7'b0000001, 0, 2'b10, "R11 still draining");
    step(7'b0000000, 0, 2'b10, "R11 fifo empties");
    expect_state(0, 2'b10, "R11 back to rx");

    // acknowledge preset
    cfg(2'b10, 3'd1, 3'd3);
    step(0, 1, 2'b11, "R11 ack preset final");
    step(7'b0100000, 0, 2'b11, "R11 packet sent");
    expect_state(1, 2'b10, "R11 listen for ack");
    step(7'b0000000, 0, 2'b11, "R11 waiting");
    step(7'b0000100, 0, 2'b11, "R11 ack crc");
    expect_state(0, 2'b11, "R11 back to tx");

    // falling fne start
    cfg(2'b01, 3'd7, 3'd6);
    step(7'b0000001, 0, 0, "R4 fne high");
    step(7'b0000000, 0, 0, "R4 start on fne fall");
    expect_state(1, 2'b01, "R4 fne fall start");
    step(7'b0100000, 0, 0, "R5 end on sent");

    // pseudo-random sweep over all codes
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 37 == 0) cfg(lf[1:0], lf[4:2], lf[7:5]);
      step(lf[14:8] & {lf[6:0] | lf[15:9]}, (lf[4:0] == 5'd3), lf[9:8], "R4 R5 R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule